// File: doc/BRIEF.md
# Interrupt Source Router

This block holds the per-source vector/priority and destination registers of an interrupt controller and decides which CPU output stages are offered each pending source. Every source input is captured as level- or edge-sensitive (chosen per source at build time). A source is then qualified by its mask, its priority and its in-service flag. It is delivered either to every CPU named in its destination register (directed mode) or to a single target CPU picked round-robin from a pointer to the CPU that last received it (distributed mode). Sense and delivery mode are build-time parameters per source and cannot be written from the register port.

A scanner visits one source per clock, in increasing index order, and wraps around. Each source is therefore re-qualified within `NUM_SRC` cycles of any input change or register write. An offer is a registered, one-cycle pulse that carries a per-CPU bit mask, the source index, its priority and its vector, for use by per-CPU arbitration stages. When a source is offered, its in-service flag is set. The downstream acknowledge logic clears that flag through `act_clr`, or a level source clears it by dropping its input.

Top module: `irq_route`

## Requirements
- R1: After reset every source reads with mask bit 31 set, priority 0, vector 0 and in-service bit 30 clear. Bit 29 reads 1 for distributed sources, and bit 22 reads 1 for level sources. Every destination register reads 1 (CPU 0 only), and no offer is made.
- R2: A write with `reg_sel`=0 changes only mask (bit 31), priority (bits 19:16) and vector (bits VEC_W-1:0). Bits 30, 29 and 22 and all other bits are not changed by the write. A write with `reg_sel`=1 keeps only destination bits NUM_CPU-1:0.
- R3: A source is offered only when all of these hold: it is pending, it is unmasked, its priority is nonzero, it is not in service and its destination register is nonzero. An edge that arrives while any of these is false stays pending until the source qualifies.
- R4: For an edge source, a rising input sets pending, and an offer clears it. An input held high yields one offer only.
- R5: For a level source, pending equals the current input level, so a level that is dropped while the source is masked leaves nothing pending. A low input clears the in-service bit.
- R6: An offer sets the source's in-service bit, which blocks further offers until `act_clr` clears it. An edge that arrived in the meantime is then offered.
- R7: A directed source is offered to every CPU whose destination bit is set, all in one offer.
- R8: A distributed source is offered to exactly one CPU. It is the first CPU with its destination bit set, searching from the last CPU used plus one and wrapping, and the last-CPU pointer is updated to that CPU. The pointer starts at 0.
- R9: Offers are registered pulses of at most one source per cycle, carrying index, priority and vector. Several sources that become pending together are all offered within NUM_SRC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Source inputs, active high |
| act_clr | input | NUM_SRC | Per-source clear of the in-service bit |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: vector/priority register, 1: destination register |
| reg_idx | input | $clog2(NUM_SRC) | Source selected for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| offer_cpu | output | NUM_CPU | Per-CPU offer mask, zero when idle |
| offer_idx | output | $clog2(NUM_SRC) | Index of the offered source |
| offer_prio | output | 4 | Priority of the offered source |
| offer_vec | output | VEC_W | Vector of the offered source |

## Verification
The hardest case to reach is the distributed pointer walking through every CPU and wrapping back past the highest index. Reaching it needs repeated offer/clear rounds on the same source. The stimulus repeats pulse, offer and `act_clr` on one distributed edge source, with all four CPUs as targets, for four rounds. It then narrows the destination so that the search has to skip CPUs, and finally sets the destination to the one-hot of the last CPU used. Held edges and pending state that outlives a mask are reached by setting up the input before the register write that unmasks the source.

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 8,
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 8,
  parameter logic [NUM_SRC-1:0] SENSE_LVL = '0,
  parameter logic [NUM_SRC-1:0] DIST_MODE = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic [NUM_SRC-1:0]         act_clr,
  input  logic                       reg_we,
  input  logic                       reg_sel,
  input  logic [$clog2(NUM_SRC)-1:0] reg_idx,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic [NUM_CPU-1:0]         offer_cpu,
  output logic [$clog2(NUM_SRC)-1:0] offer_idx,
  output logic [3:0]                 offer_prio,
  output logic [VEC_W-1:0]           offer_vec
);
  localparam int IW = $clog2(NUM_SRC);
  localparam int CW = $clog2(NUM_CPU);

  logic [IW-1:0]      scan_q;
  logic [NUM_SRC-1:0] mask_q, act_q, epend_q, prev_q;
  logic [3:0]         prio_q [NUM_SRC];
  logic [VEC_W-1:0]   vec_q  [NUM_SRC];
  logic [NUM_CPU-1:0] dest_q [NUM_SRC];
  logic [CW-1:0]      last_q [NUM_SRC];

  wire [NUM_SRC-1:0] rise = irq_in & ~prev_q;
  wire [NUM_SRC-1:0] pend = (SENSE_LVL & irq_in) | (~SENSE_LVL & epend_q);

  logic [NUM_CPU-1:0] s_dest, route, last_oh;
  logic [CW-1:0]      s_last, rr_sel;
  logic               elig, rr_found;

  always_comb begin
    s_dest   = dest_q[scan_q];
    s_last   = last_q[scan_q];
    elig     = pend[scan_q] && !mask_q[scan_q] && (prio_q[scan_q] != 4'd0) &&
               !act_q[scan_q] && (s_dest != '0);
    rr_sel   = s_last;
    rr_found = 1'b0;
    for (int k = 1; k <= NUM_CPU; k++) begin
      int c;
      c = (int'(s_last) + k) % NUM_CPU;
      if (!rr_found && s_dest[c]) begin
        rr_sel   = CW'(c);
        rr_found = 1'b1;
      end
    end
    last_oh         = '0;
    last_oh[s_last] = 1'b1;
    route           = '0;
    if (!DIST_MODE[scan_q] || s_dest == last_oh) route = s_dest;
    else route[rr_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q     <= '0;
      mask_q     <= '1;
      act_q      <= '0;
      epend_q    <= '0;
      prev_q     <= '0;
      offer_cpu  <= '0;
      offer_idx  <= '0;
      offer_prio <= '0;
      offer_vec  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
        dest_q[i] <= NUM_CPU'(1);
        last_q[i] <= '0;
      end
    end else begin
      scan_q <= (scan_q == IW'(NUM_SRC-1)) ? '0 : scan_q + 1'b1;
      prev_q <= irq_in;
      for (int i = 0; i < NUM_SRC; i++)
        if (act_clr[i] || (SENSE_LVL[i] && !irq_in[i])) act_q[i] <= 1'b0;
      if (elig) begin
        act_q[scan_q]   <= 1'b1;
        epend_q[scan_q] <= 1'b0;
        if (DIST_MODE[scan_q]) last_q[scan_q] <= rr_sel;
      end
      for (int i = 0; i < NUM_SRC; i++)
        if (rise[i] && !SENSE_LVL[i]) epend_q[i] <= 1'b1;
      if (reg_we && !reg_sel) begin
        mask_q[reg_idx] <= reg_wdata[31];
        prio_q[reg_idx] <= reg_wdata[19:16];
        vec_q[reg_idx]  <= reg_wdata[VEC_W-1:0];
      end
      if (reg_we && reg_sel) dest_q[reg_idx] <= reg_wdata[NUM_CPU-1:0];
      offer_cpu  <= elig ? route : '0;
      offer_idx  <= scan_q;
      offer_prio <= prio_q[scan_q];
      offer_vec  <= vec_q[scan_q];
    end
  end

  always_comb begin
    if (reg_sel) reg_rdata = 32'(dest_q[reg_idx]);
    else reg_rdata = {mask_q[reg_idx], act_q[reg_idx], DIST_MODE[reg_idx], 5'b0, 1'b0,
                      SENSE_LVL[reg_idx], 2'b0, prio_q[reg_idx], 16'(vec_q[reg_idx])};
  end

  AST_OFFER_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_cpu != '0) |-> act_q[offer_idx]); // R6
  AST_OFFER_PRIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_cpu != '0) |-> (offer_prio != 4'd0)); // R3
  AST_DIST_SINGLE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    ((offer_cpu != '0) && DIST_MODE[offer_idx]) |-> ($countones(offer_cpu) == 1)); // R8

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    if (SENSE_LVL[g]) begin : g_chk
      AST_LEVEL_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!irq_in[g]) |-> !act_q[g]); // R5
    end
  end
endmodule

// File: tb/irq_route_tb.sv
module irq_route_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int VW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0, act_clr = '0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [2:0] reg_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NC-1:0] offer_cpu;
  logic [2:0] offer_idx;
  logic [3:0] offer_prio;
  logic [VW-1:0] offer_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route #(.NUM_SRC(NS), .NUM_CPU(NC), .VEC_W(VW),
              .SENSE_LVL(8'hF0), .DIST_MODE(8'hCC)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .act_clr(act_clr),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .offer_cpu(offer_cpu), .offer_idx(offer_idx),
    .offer_prio(offer_prio), .offer_vec(offer_vec));

  typedef struct { logic [NC-1:0] cpu; logic [2:0] idx; logic [3:0] prio; logic [VW-1:0] vec; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  string phase = "R1";

  always @(negedge clk) begin
    if (rst_n && offer_cpu != '0) begin
      int hit;
      hit = -1;
      foreach (exp_q[i])
        if (hit < 0 && exp_q[i].cpu == offer_cpu && exp_q[i].idx == offer_idx &&
            exp_q[i].prio == offer_prio && exp_q[i].vec == offer_vec) hit = i;
      checks++;
      if (hit < 0) begin
        errors++;
        if (exp_q.size() > 0)
          $display("FAIL %s: offer cpu=%b idx=%0d prio=%0d vec=%h, expected cpu=%b idx=%0d prio=%0d vec=%h",
                   phase, offer_cpu, offer_idx, offer_prio, offer_vec,
                   exp_q[0].cpu, exp_q[0].idx, exp_q[0].prio, exp_q[0].vec);
        else
          $display("FAIL %s: offer cpu=%b idx=%0d prio=%0d vec=%h, expected no offer",
                   phase, offer_cpu, offer_idx, offer_prio, offer_vec);
      end else exp_q.delete(hit);
    end
  end

  task automatic wr(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_idx = 3'(idx); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input int idx, input logic [31:0] e, input string tag);
    @(negedge clk); reg_sel = sel; reg_idx = 3'(idx); #1;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: reg sel=%0d idx=%0d actual=%h expected=%h", tag, sel, idx, reg_rdata, e);
    end
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic clr(input int idx);
    @(negedge clk); act_clr[idx] = 1'b1;
    @(negedge clk); act_clr = '0;
  endtask

  task automatic push(input logic [NC-1:0] c, input int idx, input int p, input logic [VW-1:0] v, input string tag);
    item_t it;
    it.cpu = c; it.idx = 3'(idx); it.prio = 4'(p); it.vec = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drain(input string tag);
    repeat (NS + 4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: missing offers actual=%0d outstanding expected=0 (first idx=%0d cpu=%b)",
               tag, exp_q.size(), exp_q[0].idx, exp_q[0].cpu);
      exp_q.delete();
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3); rst_n = 1'b1;
    phase = "R1";
    rd(0, 0, 32'h8000_0000, "R1");
    rd(0, 2, 32'hA000_0000, "R1");
    rd(0, 4, 32'h8040_0000, "R1");
    rd(0, 6, 32'hA040_0000, "R1");
    rd(1, 5, 32'h0000_0001, "R1");
    drain("R1");

    phase = "R3";
    pulse(8'h01);
    drain("R3");
    push(4'b0001, 0, 5, 8'h33, "R3");
    wr(0, 0, 32'h0005_0033);
    drain("R3");
    phase = "R6";
    rd(0, 0, 32'h4005_0033, "R6");
    clr(0);

    phase = "R2";
    wr(0, 1, 32'hFFFF_FFFF);
    rd(0, 1, 32'h800F_00FF, "R2");
    wr(1, 1, 32'hFFFF_FFFF);
    rd(1, 1, 32'h0000_000F, "R2");
    wr(0, 1, 32'h0000_0000);
    rd(0, 1, 32'h0000_0000, "R2");

    phase = "R3";
    pulse(8'h02);
    drain("R3");
    wr(1, 1, 32'h0);
    wr(0, 1, 32'h0003_0000);
    drain("R3");
    phase = "R7";
    push(4'b0110, 1, 3, 8'h00, "R7");
    wr(1, 1, 32'h6);
    drain("R7");

    phase = "R6";
    pulse(8'h02);
    drain("R6");
    push(4'b0110, 1, 3, 8'h00, "R6");
    clr(1);
    drain("R6");
    clr(1);

    phase = "R4";
    push(4'b0001, 0, 5, 8'h33, "R4");
    @(negedge clk); irq_in[0] = 1'b1;
    drain("R4");
    clr(0);
    drain("R4");
    @(negedge clk); irq_in[0] = 1'b0;

    phase = "R8";
    wr(0, 2, 32'h0002_0011);
    wr(1, 2, 32'hF);
    push(4'b0010, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);
    push(4'b0100, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);
    push(4'b1000, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);
    push(4'b0001, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);
    wr(1, 2, 32'h5);
    push(4'b0100, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);
    wr(1, 2, 32'h4);
    push(4'b0100, 2, 2, 8'h11, "R8"); pulse(8'h04); drain("R8"); clr(2);

    phase = "R5";
    wr(0, 4, 32'h0004_0044);
    wr(1, 4, 32'h3);
    push(4'b0011, 4, 4, 8'h44, "R5");
    @(negedge clk); irq_in[4] = 1'b1;
    drain("R5");
    rd(0, 4, 32'h4044_0044, "R5");
    @(negedge clk); irq_in[4] = 1'b0;
    wait_n(2);
    rd(0, 4, 32'h0044_0044, "R5");
    push(4'b0011, 4, 4, 8'h44, "R5");
    @(negedge clk); irq_in[4] = 1'b1;
    drain("R5");
    @(negedge clk); irq_in[4] = 1'b0;
    wait_n(2);
    wr(0, 4, 32'h8004_0044);
    @(negedge clk); irq_in[4] = 1'b1;
    wait_n(3);
    @(negedge clk); irq_in[4] = 1'b0;
    wait_n(2);
    wr(0, 4, 32'h0004_0044);
    drain("R5");

    phase = "R8";
    wr(0, 6, 32'h0001_0066);
    wr(1, 6, 32'hA);
    push(4'b0010, 6, 1, 8'h66, "R8");
    @(negedge clk); irq_in[6] = 1'b1; drain("R8");
    @(negedge clk); irq_in[6] = 1'b0; wait_n(2);
    push(4'b1000, 6, 1, 8'h66, "R8");
    @(negedge clk); irq_in[6] = 1'b1; drain("R8");
    @(negedge clk); irq_in[6] = 1'b0; wait_n(2);
    push(4'b0010, 6, 1, 8'h66, "R8");
    @(negedge clk); irq_in[6] = 1'b1; drain("R8");
    @(negedge clk); irq_in[6] = 1'b0; wait_n(2);

    phase = "R9";
    push(4'b0001, 0, 5, 8'h33, "R9");
    push(4'b0110, 1, 3, 8'h00, "R9");
    push(4'b0100, 2, 2, 8'h11, "R9");
    pulse(8'h07);
    drain("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule